// File: doc/BRIEF.md
# Translation Table Walker

This block resolves a logical address into a physical one after the translation cache misses. It accepts the missed logical address and function code, selects one of two root pointers, and walks a tree of tables in physical memory. It issues one descriptor read per level over a request/response memory port. It follows table descriptors downward until it reaches a page descriptor, and then it returns the finished translation to the cache in a single-cycle completion pulse.

The shape of the tree is set at run time. Each of up to four address levels is given an index width from 0 to 15 bits, and a width of 0 drops that level. A separate control bit adds a first level that is indexed by the function code. Index fields are taken from the top of the logical address downward. Whatever bits the walk has not used when it reaches a page descriptor pass straight through as the page offset. A bad configuration, an invalid descriptor, or a table pointer with no level left to follow ends the walk with a fault code and no translation.

Top module: `table_walker`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `mem_req_valid`, `done` and `fill_valid` are all 0.
- R2: The first table base is `root_ptr1` when `root_sel` is 1 and `root_ptr0` otherwise, with its two low bits cleared. Each descriptor read address is table base plus index times 4, so it is always 4-byte aligned.
- R3: Level k (k = 0..3) has an index width given by `cfg_lvl_bits[4k+3:4k]`, from 0 to 15. Level 0 is the outermost level. Each level with a nonzero width takes the next most significant unused bits of the logical address as its index.
- R4: A level whose width is 0 causes no memory read and uses no address bits. The walk continues with the next nonzero level.
- R5: When `cfg_fc_first` is 1, the first read is at root plus function code times 4. The address levels follow, starting from bit 31 of the logical address.
- R6: The descriptor type is in bits [1:0]: 2'b10 is a table pointer, 2'b01 is a page, and 2'b00 and 2'b11 are invalid. The base of the next table is the descriptor with bits [1:0] cleared. This address is used without translation.
- R7: On a page descriptor, `fill_paddr` is built from two parts. Address bits consumed by the levels walked so far, including the current one, come from the descriptor. Lower bits come from the logical address. `fill_valid` is 1, `fault_code` is 0, and `fill_vaddr` and `fill_fc` echo the miss.
- R8: An invalid descriptor ends the walk with `fault_code` 2'b01 and `fill_valid` 0, and no further read is made.
- R9: A table pointer read at the last configured level ends the walk with `fault_code` 2'b10 and `fill_valid` 0.
- R10: A configuration whose widths sum to more than 32 bits, or that has no level at all, ends with `fault_code` 2'b11 without any memory read. `done` rises one cycle after the miss is accepted.
- R11: A descriptor request stays asserted with a constant address until `mem_req_ready` is sampled high. Only one read is outstanding at a time.
- R12: `done` is a single-cycle pulse that comes the cycle after the final response is accepted. A miss is accepted only while `busy` is 0, and a miss offered while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Translation miss to resolve |
| miss_vaddr | input | 32 | Logical address that missed |
| miss_fc | input | 3 | Function code of the missed access |
| root_sel | input | 1 | Selects root pointer 1 when high |
| root_ptr0 | input | 32 | Root table pointer 0 (physical) |
| root_ptr1 | input | 32 | Root table pointer 1 (physical) |
| cfg_lvl_bits | input | 16 | Index width of each of four levels, 4 bits each |
| cfg_fc_first | input | 1 | Adds a first level indexed by the function code |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Physical descriptor address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor read from memory |
| done | output | 1 | Walk finished (one-cycle pulse) |
| fill_valid | output | 1 | Translation is valid for the cache to store |
| fill_vaddr | output | 32 | Logical address of the translation |
| fill_fc | output | 3 | Function code of the translation |
| fill_paddr | output | 32 | Resulting physical address |
| fault_code | output | 2 | 0 ok, 1 invalid descriptor, 2 no page at last level, 3 bad configuration |

## Verification
`done` is registered after the response handshake, so it must appear exactly one cycle after the cycle in which the bench's memory model drives `mem_rsp_valid`. For a rejected configuration, it must appear one cycle after the cycle in which the bench offered the miss. The bench records the cycle number of each of those stimuli and compares it with the cycle in which it first sees `done`. It samples on the falling edge, so every registered change has already settled. A further check one cycle later confirms that `done` has dropped. Descriptor addresses are logged at the handshake cycle. During memory stalls, the model compares the held address on every stall cycle.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        DK_BAD_LO = 2'b00,
        DK_PAGE   = 2'b01,
        DK_TABLE  = 2'b10,
        DK_BAD_HI = 2'b11
    } desc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_NO_PAGE = 2'd2,
        FLT_BAD_CFG = 2'd3
    } walk_fault_e;

    // descriptors are 4 bytes wide
    localparam int DESC_ADDR_SHIFT = 2;

    function automatic desc_kind_e decode_kind(input logic [1:0] tbits);
        return desc_kind_e'(tbits);
    endfunction

endpackage

// File: rtl/tw_cfg_check.sv
module tw_cfg_check #(
    parameter int ADDR_W = 32,
    parameter int LEVELS = 4,
    parameter int WBITS  = 4
) (
    input  logic [LEVELS*WBITS-1:0] lvl_bits,
    input  logic                    fc_first,
    output logic                    ok
);
    localparam int MAX_SUM = LEVELS * ((1 << WBITS) - 1);
    localparam int SUM_W   = $clog2(MAX_SUM + 1);

    logic [WBITS-1:0] width_of [LEVELS];
    logic [SUM_W-1:0] total;

    genvar g;
    generate
        for (g = 0; g < LEVELS; g++) begin : g_unpack
            assign width_of[g] = lvl_bits[g*WBITS +: WBITS];
        end
    endgenerate

    always_comb begin
        total = '0;
        for (int i = 0; i < LEVELS; i++) begin
            total = total + SUM_W'(width_of[i]);
        end
    end

    // sum must fit the address and at least one level must exist
    assign ok = (int'(total) <= ADDR_W) && ((|lvl_bits) || fc_first);

endmodule

// File: rtl/tw_next_level.sv
module tw_next_level #(
    parameter int LEVELS = 4,
    parameter int WBITS  = 4,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic [LEVELS*WBITS-1:0] lvl_bits,
    input  logic [LVL_W:0]          start,
    output logic                    found,
    output logic [LVL_W-1:0]        idx
);
    logic nonzero [LEVELS];

    genvar g;
    generate
        for (g = 0; g < LEVELS; g++) begin : g_nz
            assign nonzero[g] = |lvl_bits[g*WBITS +: WBITS];
        end
    endgenerate

    // lowest-numbered nonzero level at or after start
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = LEVELS - 1; i >= 0; i--) begin
            if (nonzero[i] && (i >= int'(start))) begin
                found = 1'b1;
                idx   = LVL_W'(i);
            end
        end
    end

endmodule

// File: rtl/tw_desc_addr.sv
module tw_desc_addr
    import tw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int FC_W   = 3,
    parameter int WBITS  = 4,
    localparam int CNT_W = $clog2(ADDR_W + 1)
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [CNT_W-1:0]  consumed,
    input  logic [WBITS-1:0]  width,
    input  logic              use_fc,
    input  logic [FC_W-1:0]   fc,
    output logic [ADDR_W-1:0] addr
);
    localparam int SH_W = CNT_W + 1;

    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] field;
    logic [ADDR_W-1:0] idx_sel;
    logic [SH_W-1:0]   rshift;

    // drop the bits already used, then keep the top 'width' bits
    assign aligned = vaddr << consumed;
    assign rshift  = SH_W'(ADDR_W) - SH_W'(width);
    assign field   = aligned >> rshift;
    assign idx_sel = use_fc ? {{(ADDR_W-FC_W){1'b0}}, fc} : field;
    assign addr    = base + (idx_sel << DESC_ADDR_SHIFT);

endmodule

// File: rtl/table_walker.sv
module table_walker
    import tw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int FC_W   = 3,
    parameter int LEVELS = 4,
    parameter int WBITS  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    miss_valid,
    input  logic [ADDR_W-1:0]       miss_vaddr,
    input  logic [FC_W-1:0]         miss_fc,
    input  logic                    root_sel,
    input  logic [ADDR_W-1:0]       root_ptr0,
    input  logic [ADDR_W-1:0]       root_ptr1,
    input  logic [LEVELS*WBITS-1:0] cfg_lvl_bits,
    input  logic                    cfg_fc_first,
    output logic                    busy,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [ADDR_W-1:0]       mem_req_addr,
    input  logic                    mem_rsp_valid,
    input  logic [ADDR_W-1:0]       mem_rsp_data,
    output logic                    done,
    output logic                    fill_valid,
    output logic [ADDR_W-1:0]       fill_vaddr,
    output logic [FC_W-1:0]         fill_fc,
    output logic [ADDR_W-1:0]       fill_paddr,
    output logic [1:0]              fault_code
);
    localparam int LVL_W = $clog2(LEVELS);
    localparam int CNT_W = $clog2(ADDR_W + 1);
    localparam int CFG_W = LEVELS * WBITS;
    localparam logic [ADDR_W-1:0] ALIGN_MASK =
        ~ADDR_W'((1 << DESC_ADDR_SHIFT) - 1);

    walk_state_e       st;
    logic [ADDR_W-1:0] r_vaddr;
    logic [FC_W-1:0]   r_fc;
    logic [CFG_W-1:0]  r_lvl_bits;
    logic [ADDR_W-1:0] r_base;
    logic [LVL_W-1:0]  r_lvl;
    logic              r_in_fc;
    logic [CNT_W-1:0]  r_consumed;
    logic [ADDR_W-1:0] r_paddr;
    walk_fault_e       r_fault;

    logic              cfg_ok;
    logic [CFG_W-1:0]  lvl_src;
    logic [LVL_W:0]    nl_start;
    logic              nl_found;
    logic [LVL_W-1:0]  nl_idx;
    logic [WBITS-1:0]  lvl_w [LEVELS];
    logic [WBITS-1:0]  cur_width;
    logic [CNT_W-1:0]  consumed_next;
    logic [ADDR_W-1:0] offmask;
    logic [ADDR_W-1:0] frame;
    logic [ADDR_W-1:0] page_pa;
    logic [ADDR_W-1:0] root_base;
    desc_kind_e        kind;

    tw_cfg_check #(
        .ADDR_W (ADDR_W),
        .LEVELS (LEVELS),
        .WBITS  (WBITS)
    ) u_cfg (
        .lvl_bits (cfg_lvl_bits),
        .fc_first (cfg_fc_first),
        .ok       (cfg_ok)
    );

    // at acceptance search the incoming config, during the walk the latched one
    assign lvl_src = (st == ST_IDLE) ? cfg_lvl_bits : r_lvl_bits;

    always_comb begin
        if (st == ST_IDLE || r_in_fc) begin
            nl_start = '0;
        end else begin
            nl_start = {1'b0, r_lvl} + 1'b1;
        end
    end

    tw_next_level #(
        .LEVELS (LEVELS),
        .WBITS  (WBITS)
    ) u_next (
        .lvl_bits (lvl_src),
        .start    (nl_start),
        .found    (nl_found),
        .idx      (nl_idx)
    );

    genvar g;
    generate
        for (g = 0; g < LEVELS; g++) begin : g_width
            assign lvl_w[g] = r_lvl_bits[g*WBITS +: WBITS];
        end
    endgenerate

    assign cur_width     = r_in_fc ? '0 : lvl_w[r_lvl];
    assign consumed_next = r_consumed + CNT_W'(cur_width);

    tw_desc_addr #(
        .ADDR_W (ADDR_W),
        .FC_W   (FC_W),
        .WBITS  (WBITS)
    ) u_addr (
        .base     (r_base),
        .vaddr    (r_vaddr),
        .consumed (r_consumed),
        .width    (cur_width),
        .use_fc   (r_in_fc),
        .fc       (r_fc),
        .addr     (mem_req_addr)
    );

    // page result: consumed bits from the frame, the rest from the logical address
    assign offmask   = {ADDR_W{1'b1}} >> consumed_next;
    assign frame     = mem_rsp_data & ALIGN_MASK;
    assign page_pa   = (frame & ~offmask) | (r_vaddr & offmask);
    assign kind      = decode_kind(mem_rsp_data[1:0]);
    assign root_base = (root_sel ? root_ptr1 : root_ptr0) & ALIGN_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            r_vaddr    <= '0;
            r_fc       <= '0;
            r_lvl_bits <= '0;
            r_base     <= '0;
            r_lvl      <= '0;
            r_in_fc    <= 1'b0;
            r_consumed <= '0;
            r_paddr    <= '0;
            r_fault    <= FLT_NONE;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (miss_valid) begin
                        r_vaddr    <= miss_vaddr;
                        r_fc       <= miss_fc;
                        r_lvl_bits <= cfg_lvl_bits;
                        r_base     <= root_base;
                        r_consumed <= '0;
                        r_paddr    <= '0;
                        if (!cfg_ok) begin
                            r_fault <= FLT_BAD_CFG;
                            st      <= ST_DONE;
                        end else begin
                            r_fault <= FLT_NONE;
                            r_in_fc <= cfg_fc_first;
                            r_lvl   <= cfg_fc_first ? '0 : nl_idx;
                            st      <= ST_REQ;
                        end
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) begin
                        st <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        unique case (kind)
                            DK_PAGE: begin
                                r_paddr    <= page_pa;
                                r_consumed <= consumed_next;
                                st         <= ST_DONE;
                            end
                            DK_TABLE: begin
                                if (nl_found) begin
                                    r_base     <= frame;
                                    r_lvl      <= nl_idx;
                                    r_in_fc    <= 1'b0;
                                    r_consumed <= consumed_next;
                                    st         <= ST_REQ;
                                end else begin
                                    r_fault <= FLT_NO_PAGE;
                                    st      <= ST_DONE;
                                end
                            end
                            default: begin
                                r_fault <= FLT_INVALID;
                                st      <= ST_DONE;
                            end
                        endcase
                    end
                end
                ST_DONE: begin
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy          = (st != ST_IDLE);
    assign mem_req_valid = (st == ST_REQ);
    assign done          = (st == ST_DONE);
    assign fill_valid    = done && (r_fault == FLT_NONE);
    assign fill_vaddr    = r_vaddr;
    assign fill_fc       = r_fc;
    assign fill_paddr    = r_paddr;
    assign fault_code    = done ? r_fault : FLT_NONE;

endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              done,
    input logic              fill_valid,
    input logic [1:0]        fault_code
);
    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> busy); // R11

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00)); // R2

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R12

    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req_valid); // R12

    AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> (done && fault_code == 2'd0)); // R7

    AST_FAULT_NO_FILL: assert property (@(posedge clk) disable iff (rst)
        (done && fault_code != 2'd0) |-> !fill_valid); // R8

    AST_FAULT_ONLY_DONE: assert property (@(posedge clk) disable iff (rst)
        (fault_code != 2'd0) |-> done); // R9

endmodule

bind table_walker tw_checker #(.ADDR_W(ADDR_W)) u_tw_checker (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .done          (done),
    .fill_valid    (fill_valid),
    .fault_code    (fault_code)
);

// File: tb/tb_table_walker.sv
`timescale 1ns/1ps
module tb_table_walker;

    logic        clk = 1'b0;
    logic        rst;
    logic        miss_valid;
    logic [31:0] miss_vaddr;
    logic [2:0]  miss_fc;
    logic        root_sel;
    logic [31:0] root_ptr0;
    logic [31:0] root_ptr1;
    logic [15:0] cfg_lvl_bits;
    logic        cfg_fc_first;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        done;
    logic        fill_valid;
    logic [31:0] fill_vaddr;
    logic [2:0]  fill_fc;
    logic [31:0] fill_paddr;
    logic [1:0]  fault_code;

    always #2 clk = ~clk;

    table_walker dut (
        .clk           (clk),
        .rst           (rst),
        .miss_valid    (miss_valid),
        .miss_vaddr    (miss_vaddr),
        .miss_fc       (miss_fc),
        .root_sel      (root_sel),
        .root_ptr0     (root_ptr0),
        .root_ptr1     (root_ptr1),
        .cfg_lvl_bits  (cfg_lvl_bits),
        .cfg_fc_first  (cfg_fc_first),
        .busy          (busy),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (done),
        .fill_valid    (fill_valid),
        .fill_vaddr    (fill_vaddr),
        .fill_fc       (fill_fc),
        .fill_paddr    (fill_paddr),
        .fault_code    (fault_code)
    );

    logic [31:0] mem [0:255];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    int          nreq;
    logic [31:0] req_log [0:7];
    int          rsp_cyc;
    int          miss_cyc;
    int          done_cyc;
    int          stall_set = 0;
    int          lat_set = 1;
    int          stall_err = 0;
    logic [31:0] got_paddr;
    logic [31:0] got_vaddr;
    logic [2:0]  got_fc;
    logic [1:0]  got_fault;
    logic        got_fill;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        mem[a[9:2]] = d;
    endtask

    function automatic logic [15:0] widths(input int w0, input int w1, input int w2, input int w3);
        return {4'(w3), 4'(w2), 4'(w1), 4'(w0)};
    endfunction

    // memory model: optional stall before ready, fixed latency to the response
    task automatic mem_server();
        int          scnt = 0;
        logic [31:0] hold_a = '0;
        logic [31:0] cap = '0;
        forever begin
            @(negedge clk);
            if (rst) begin
                mem_req_ready = 1'b0;
                mem_rsp_valid = 1'b0;
                scnt = 0;
            end else if (mem_req_ready) begin
                mem_req_ready = 1'b0;
                scnt = 0;
                repeat (lat_set - 1) @(negedge clk);
                mem_rsp_data  = mem[cap[9:2]];
                mem_rsp_valid = 1'b1;
                rsp_cyc = cyc;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end else if (mem_req_valid) begin
                if (scnt == 0) hold_a = mem_req_addr;
                else if (mem_req_addr !== hold_a) stall_err++;
                if (scnt < stall_set) begin
                    scnt++;
                end else begin
                    mem_req_ready = 1'b1;
                    cap = mem_req_addr;
                    if (nreq < 8) req_log[nreq] = mem_req_addr;
                    nreq++;
                end
            end
        end
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 500) begin
            @(negedge clk);
            t++;
        end
        if (!done) chk(1'b0, "walk timeout", 32'(t), 32'd0);
        done_cyc  = cyc;
        got_paddr = fill_paddr;
        got_vaddr = fill_vaddr;
        got_fc    = fill_fc;
        got_fault = fault_code;
        got_fill  = fill_valid;
        @(negedge clk);
        chk_eq("R12 done pulse width", {31'd0, done}, 32'd0);
    endtask

    task automatic start_miss(input logic [31:0] va, input logic [2:0] fc, input logic rs,
                              input logic [15:0] lb, input logic ff);
        @(negedge clk);
        cfg_lvl_bits = lb;
        cfg_fc_first = ff;
        root_sel     = rs;
        miss_vaddr   = va;
        miss_fc      = fc;
        miss_valid   = 1'b1;
        nreq         = 0;
        miss_cyc     = cyc;
        @(negedge clk);
        miss_valid   = 1'b0;
    endtask

    task automatic run_walk(input logic [31:0] va, input logic [2:0] fc, input logic rs,
                            input logic [15:0] lb, input logic ff);
        start_miss(va, fc, rs, lb, ff);
        wait_done();
    endtask

    task automatic t_reset();
        chk_eq("R1 busy in reset", {31'd0, busy}, 32'd0);
        chk_eq("R1 req in reset", {31'd0, mem_req_valid}, 32'd0);
        chk_eq("R1 done in reset", {31'd0, done}, 32'd0);
        chk_eq("R1 fill in reset", {31'd0, fill_valid}, 32'd0);
    endtask

    task automatic t_two_level();
        run_walk(32'hA512_3456, 3'd2, 1'b0, widths(4, 4, 0, 0), 1'b0);
        chk_eq("R2 first read root0+idx*4", req_log[0], 32'h0000_0128);
        chk_eq("R3 second index from next bits", req_log[1], 32'h0000_0214);
        chk_eq("R6 read count", 32'(nreq), 32'd2);
        chk_eq("R7 page address", got_paddr, 32'hCD12_3456);
        chk_eq("R7 fill valid", {31'd0, got_fill}, 32'd1);
        chk_eq("R7 fault none", {30'd0, got_fault}, 32'd0);
        chk_eq("R7 vaddr echo", got_vaddr, 32'hA512_3456);
        chk_eq("R7 fc echo", {29'd0, got_fc}, 32'd2);
        chk_eq("R12 done one cycle after response", 32'(done_cyc), 32'(rsp_cyc + 1));
    endtask

    task automatic t_root1_skip();
        run_walk(32'hF3AB_CDEF, 3'd0, 1'b1, widths(0, 3, 0, 5), 1'b0);
        chk_eq("R2 root1 selected", req_log[0], 32'h0000_031C);
        chk_eq("R4 skipped level no read, second addr", req_log[1], 32'h0000_03CC);
        chk_eq("R4 read count with zero levels", 32'(nreq), 32'd2);
        chk_eq("R4 page address", got_paddr, 32'h77AB_CDEF);
    endtask

    task automatic t_fc_first();
        run_walk(32'h0300_0FFC, 3'd5, 1'b0, widths(8, 0, 0, 0), 1'b1);
        chk_eq("R5 fc level address", req_log[0], 32'h0000_0114);
        chk_eq("R5 address level after fc", req_log[1], 32'h0000_004C);
        chk_eq("R5 page address", got_paddr, 32'h5A00_0FFC);
        chk_eq("R5 fc echo", {29'd0, got_fc}, 32'd5);
    endtask

    task automatic t_early_page();
        run_walk(32'h6789_ABCD, 3'd1, 1'b0, widths(4, 4, 4, 0), 1'b0);
        chk_eq("R7 early page single read", 32'(nreq), 32'd1);
        chk_eq("R7 early page offset width", got_paddr, 32'hF789_ABCD);
        chk_eq("R7 early page fill", {31'd0, got_fill}, 32'd1);
    endtask

    task automatic t_invalid();
        run_walk(32'h1000_0000, 3'd0, 1'b0, widths(4, 0, 0, 0), 1'b0);
        chk_eq("R8 type 00 fault", {30'd0, got_fault}, 32'd1);
        chk_eq("R8 type 00 no fill", {31'd0, got_fill}, 32'd0);
        run_walk(32'hA600_0000, 3'd0, 1'b0, widths(4, 4, 4, 0), 1'b0);
        chk_eq("R8 type 11 fault", {30'd0, got_fault}, 32'd1);
        chk_eq("R8 no read after invalid", 32'(nreq), 32'd2);
        chk_eq("R6 invalid at 0x218", req_log[1], 32'h0000_0218);
    endtask

    task automatic t_no_page();
        run_walk(32'hA000_0000, 3'd0, 1'b0, widths(4, 0, 0, 0), 1'b0);
        chk_eq("R9 pointer at last level fault", {30'd0, got_fault}, 32'd2);
        chk_eq("R9 no fill", {31'd0, got_fill}, 32'd0);
        chk_eq("R9 read count", 32'(nreq), 32'd1);
        run_walk(32'h0000_0000, 3'd5, 1'b0, widths(0, 0, 0, 0), 1'b1);
        chk_eq("R9 fc-only pointer fault", {30'd0, got_fault}, 32'd2);
    endtask

    task automatic t_bad_cfg();
        run_walk(32'h1234_5678, 3'd0, 1'b0, widths(15, 15, 3, 0), 1'b0);
        chk_eq("R10 oversize fault", {30'd0, got_fault}, 32'd3);
        chk_eq("R10 no memory read", 32'(nreq), 32'd0);
        chk_eq("R10 done timing", 32'(done_cyc), 32'(miss_cyc + 1));
        run_walk(32'h1234_5678, 3'd0, 1'b0, widths(0, 0, 0, 0), 1'b0);
        chk_eq("R10 empty config fault", {30'd0, got_fault}, 32'd3);
        chk_eq("R10 empty config no read", 32'(nreq), 32'd0);
    endtask

    task automatic t_wide_level();
        run_walk(32'hFFFF_0000, 3'd0, 1'b0, widths(15, 0, 0, 0), 1'b0);
        chk_eq("R3 fifteen-bit index address", req_log[0], 32'h0002_00FC);
        chk_eq("R3 aliased slot is invalid", {30'd0, got_fault}, 32'd1);
    endtask

    task automatic t_stall();
        stall_set = 3;
        lat_set   = 3;
        stall_err = 0;
        run_walk(32'hA512_3456, 3'd2, 1'b0, widths(4, 4, 0, 0), 1'b0);
        chk_eq("R11 address held during stall", 32'(stall_err), 32'd0);
        chk_eq("R11 stalled walk result", got_paddr, 32'hCD12_3456);
        chk_eq("R11 stalled read count", 32'(nreq), 32'd2);
        chk_eq("R12 done after delayed response", 32'(done_cyc), 32'(rsp_cyc + 1));
        stall_set = 0;
        lat_set   = 1;
    endtask

    task automatic t_busy_miss();
        start_miss(32'h6789_ABCD, 3'd1, 1'b0, widths(4, 4, 4, 0), 1'b0);
        miss_vaddr = 32'hA512_3456;
        miss_fc    = 3'd6;
        miss_valid = 1'b1;
        @(negedge clk);
        miss_valid = 1'b0;
        wait_done();
        chk_eq("R12 busy miss ignored vaddr", got_vaddr, 32'h6789_ABCD);
        chk_eq("R12 busy miss ignored fc", {29'd0, got_fc}, 32'd1);
        chk_eq("R12 busy miss no extra read", 32'(nreq), 32'd1);
        repeat (3) @(negedge clk);
        chk_eq("R12 idle after ignored miss", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst           = 1'b1;
        miss_valid    = 1'b0;
        miss_vaddr    = '0;
        miss_fc       = '0;
        root_sel      = 1'b0;
        root_ptr0     = 32'h0000_0102;
        root_ptr1     = 32'h0000_0300;
        cfg_lvl_bits  = '0;
        cfg_fc_first  = 1'b0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        nreq          = 0;
        rsp_cyc       = 0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 8; i++) req_log[i] = '0;
        poke(32'h128, 32'h0000_0202);
        poke(32'h214, 32'hCD00_0001);
        poke(32'h218, 32'h0000_0003);
        poke(32'h31C, 32'h0000_0382);
        poke(32'h3CC, 32'h7700_0001);
        poke(32'h114, 32'h0000_0042);
        poke(32'h04C, 32'h5A00_0001);
        poke(32'h118, 32'hF000_0001);
        poke(32'h104, 32'h0000_0000);
        poke(32'h100, 32'h0000_0000);
        fork
            mem_server();
        join_none
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_two_level();
        t_root1_skip();
        t_fc_first();
        t_early_page();
        t_invalid();
        t_no_page();
        t_bad_cfg();
        t_wide_level();
        t_stall();
        t_busy_miss();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule